// File: doc/BRIEF.md
# Mixed-Sign Low-Precision Multiply-Accumulate Element

This processing element is one cell of an integer-only inference datapath. Each valid beat carries a signed weight and an unsigned activation. The element multiplies them and adds the product into a narrow signed accumulator. No zero-point is subtracted from either operand, because the quantization is symmetric. At the first beat of every output term, the accumulator is seeded with a signed 8-bit bias. The bias shares the scale of the weight-activation product, so it is added as it is, with no rescaling.

A precision input chooses how the operand lanes are read. In the wide setting the weight is a 4-bit two's-complement value and the activation is a 4-bit unsigned value. In the narrow setting only the two low bits of each lane count: the weight is sign-extended from bit 1 and the activation is zero-extended. Every product fits in 8 signed bits. The accumulator is only 16 bits wide, so every sum is clamped to the signed 16-bit limits instead of wrapping. A clamp raises a sticky flag that stays set for the rest of that output.

A beat flagged last ends the output. One cycle later the partial sum is presented with a one-cycle valid pulse. The element then ignores operand beats until the next start beat.

Top module: `mixsign_mac_pe`

## Requirements
- R1: After a synchronous active-low reset, `psum_o` is 0, `psum_valid_o` is 0 and `ovf_o` is 0.
- R2: A valid beat with `start_i`=1 loads the accumulator with the sign-extended `bias_i` plus that beat's product, with no zero-point subtracted from either operand. The result is visible on `psum_o` after that clock edge.
- R3: A sum below -32768 is stored as -32768, and a sum above 32767 is stored as 32767. The accumulator never wraps.
- R4: `ovf_o` rises on the edge that stores a clamped sum. It stays high through later beats of the same output, including its final valid, and is cleared by the next start beat.
- R5: With `prec_i`=0, `wgt_i` is a signed 4-bit value (-8..7) and `act_i` is an unsigned 4-bit value (0..15).
- R6: With `prec_i`=1, only `wgt_i[1:0]` (signed, -2..1) and `act_i[1:0]` (unsigned, 0..3) are used. Bits 3:2 of both lanes have no effect.
- R7: For a beat accepted with `last_i`=1, `psum_valid_o` is high for exactly the next cycle, and `psum_o` then holds the final sum.
- R8: After a last beat, valid beats without `start_i` change neither `psum_o` nor `psum_valid_o`.
- R9: While `in_valid_i` is 0, `start_i`, `last_i` and the operands have no effect, and `psum_o` holds its value.
- R10: A beat with both `start_i` and `last_i` set yields a one-term output: the bias plus a single product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prec_i | input | 1 | Precision select: 0 = 4-bit operands, 1 = 2-bit operands |
| in_valid_i | input | 1 | Qualifies the beat |
| start_i | input | 1 | First beat of an output; seeds the accumulator with the bias |
| last_i | input | 1 | Final beat of an output |
| bias_i | input | 8 | Signed bias, used on start beats |
| wgt_i | input | 4 | Weight lane (signed) |
| act_i | input | 4 | Activation lane (unsigned) |
| psum_o | output | 16 | Accumulator value (signed) |
| psum_valid_o | output | 1 | One-cycle pulse marking a finished partial sum |
| ovf_o | output | 1 | Sticky clamp flag for the current output |

## Verification
The hardest conditions to reach are the two clamp limits. The largest product is 105 and the smallest is -120, so hundreds of consecutive beats are needed before the 16-bit range runs out. Directed runs start from a bias of 127 or -128 and repeat the extreme product about 300 times. They then check that the value pins at the limit and that the flag stays set. After that, a product of the opposite sign is added to show that the clamped value is still a live accumulator. A new start beat then clears the flag. The narrow setting is driven with the upper lane bits deliberately set, so that any use of those bits changes the result.

// File: rtl/mac_pe_pkg.sv
// Package: shared types and fixed operand geometry for the MAC element.
// Assumes: lanes are at most 4 bits wide; the narrow setting uses 2 of them.
package mac_pe_pkg;

    // Operand interpretation selected by prec_i
    typedef enum logic {
        PREC_WIDE   = 1'b0,
        PREC_NARROW = 1'b1
    } prec_e;

    // Number of significant lane bits in the narrow setting
    localparam int unsigned NARROW_BITS = 2;

endpackage

// File: rtl/mac_operand_decode.sv
// Module: mac_operand_decode
// Turns the raw lanes into a signed weight and an unsigned activation,
// both OPW bits wide, according to the precision setting.
// Assumes: OPW >= NARROW_BITS. Narrow weights are sign-extended from
// their top used bit; narrow activations are zero-extended.
module mac_operand_decode
    import mac_pe_pkg::*;
#(
    parameter int unsigned OPW = 4
) (
    input  prec_e           prec,
    input  logic [OPW-1:0]  wgt_raw,
    input  logic [OPW-1:0]  act_raw,
    output logic [OPW-1:0]  wgt_dec,
    output logic [OPW-1:0]  act_dec
);

    localparam int unsigned NB  = NARROW_BITS;
    localparam int unsigned EXT = OPW - NB;

    logic [OPW-1:0] wgt_narrow;
    logic [OPW-1:0] act_narrow;

    generate
        if (EXT > 0) begin : g_ext
            // Extend the low lane bits to full operand width
            always_comb begin
                wgt_narrow = {{EXT{wgt_raw[NB-1]}}, wgt_raw[NB-1:0]};
                act_narrow = {{EXT{1'b0}}, act_raw[NB-1:0]};
            end
        end else begin : g_noext
            // Lanes already narrow: pass through
            always_comb begin
                wgt_narrow = wgt_raw;
                act_narrow = act_raw;
            end
        end
    endgenerate

    // Pick the interpretation chosen by the precision setting
    always_comb begin
        if (prec == PREC_NARROW) begin
            wgt_dec = wgt_narrow;
            act_dec = act_narrow;
        end else begin
            wgt_dec = wgt_raw;
            act_dec = act_raw;
        end
    end

endmodule

// File: rtl/mac_mul.sv
// Module: mac_mul
// Signed-by-unsigned multiplier. The weight is two's complement and the
// activation is a magnitude, so the product lies in
// [-2^(OPW-1)*(2^OPW-1), (2^(OPW-1)-1)*(2^OPW-1)] and fits in 2*OPW bits.
// Assumes: no zero-point; the operands are used as they arrive.
module mac_mul #(
    parameter int unsigned OPW = 4,
    parameter int unsigned PW  = 2 * OPW
) (
    input  logic [OPW-1:0]  wgt,
    input  logic [OPW-1:0]  act,
    output logic [PW-1:0]   prod
);

    localparam int unsigned XW = PW + 1;

    logic signed [XW-1:0] wgt_x;
    logic signed [XW-1:0] act_x;
    logic signed [XW-1:0] full;

    // Extend the weight as signed and the activation as unsigned, then multiply
    always_comb begin
        wgt_x = $signed({{(XW-OPW){wgt[OPW-1]}}, wgt});
        act_x = $signed({{(XW-OPW){1'b0}}, act});
        full  = wgt_x * act_x;
        prod  = full[PW-1:0];
    end

endmodule

// File: rtl/mac_sat_acc.sv
// Module: mac_sat_acc
// Narrow saturating accumulator with bias preload and a sticky clamp flag.
// Assumes: load and add_en are never high unless the beat is accepted;
// when load is high, add_en is high too.
module mac_sat_acc #(
    parameter int unsigned PW     = 8,
    parameter int unsigned BIAS_W = 8,
    parameter int unsigned ACC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_en,
    input  logic              load,
    input  logic [BIAS_W-1:0] bias,
    input  logic [PW-1:0]     prod,
    output logic [ACC_W-1:0]  acc,
    output logic              ovf
);

    localparam int unsigned SW = ACC_W + 1;
    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W-1:0] base;
    logic [SW-1:0]    sum;
    logic [ACC_W-1:0] sum_sat;
    logic             clip;

    // Choose the starting point: the sign-extended bias or the running sum
    always_comb begin
        if (load) base = {{(ACC_W-BIAS_W){bias[BIAS_W-1]}}, bias};
        else      base = acc;
    end

    // Add one extra bit, then clamp when the top two bits disagree
    always_comb begin
        sum  = {base[ACC_W-1], base} + {{(SW-PW){prod[PW-1]}}, prod};
        clip = sum[SW-1] ^ sum[SW-2];
        if (!clip)          sum_sat = sum[ACC_W-1:0];
        else if (sum[SW-1]) sum_sat = ACC_MIN;
        else                sum_sat = ACC_MAX;
    end

    // Accumulator register
    always_ff @(posedge clk) begin
        if (!rst_n)      acc <= '0;
        else if (add_en) acc <= sum_sat;
    end

    // Sticky clamp flag: cleared by a preload, set by any clamp
    always_ff @(posedge clk) begin
        if (!rst_n)      ovf <= 1'b0;
        else if (add_en) ovf <= (load ? 1'b0 : ovf) | clip;
    end

endmodule

// File: rtl/mixsign_mac_pe.sv
// Module: mixsign_mac_pe (top)
// One mixed-sign multiply-accumulate element. Beats are accepted from a
// start beat up to and including a last beat; the partial sum is flagged
// valid one cycle after the last beat.
// Assumes: inputs are synchronous to clk; start_i and last_i count only
// when in_valid_i is high.
module mixsign_mac_pe
    import mac_pe_pkg::*;
#(
    parameter int unsigned OPW    = 4,
    parameter int unsigned BIAS_W = 8,
    parameter int unsigned ACC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prec_i,
    input  logic              in_valid_i,
    input  logic              start_i,
    input  logic              last_i,
    input  logic [BIAS_W-1:0] bias_i,
    input  logic [OPW-1:0]    wgt_i,
    input  logic [OPW-1:0]    act_i,
    output logic [ACC_W-1:0]  psum_o,
    output logic              psum_valid_o,
    output logic              ovf_o
);

    localparam int unsigned PW = 2 * OPW;

    prec_e          prec;
    logic [OPW-1:0] wgt_dec;
    logic [OPW-1:0] act_dec;
    logic [PW-1:0]  prod;
    logic           busy_q;
    logic           accept;
    logic           load;
    logic           valid_q;

    // Map the precision pin onto the shared enum
    always_comb prec = prec_e'(prec_i);

    mac_operand_decode #(.OPW(OPW)) dec_i (
        .prec    (prec),
        .wgt_raw (wgt_i),
        .act_raw (act_i),
        .wgt_dec (wgt_dec),
        .act_dec (act_dec)
    );

    mac_mul #(.OPW(OPW), .PW(PW)) mul_i (
        .wgt  (wgt_dec),
        .act  (act_dec),
        .prod (prod)
    );

    // Accept a beat when it starts an output or continues an open one
    always_comb begin
        load   = in_valid_i && start_i;
        accept = in_valid_i && (start_i || busy_q);
    end

    mac_sat_acc #(.PW(PW), .BIAS_W(BIAS_W), .ACC_W(ACC_W)) acc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .add_en (accept),
        .load   (load),
        .bias   (bias_i),
        .prod   (prod),
        .acc    (psum_o),
        .ovf    (ovf_o)
    );

    // Track whether an output is open; a last beat closes it
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_q <= 1'b0;
        else if (accept) busy_q <= !last_i;
    end

    // Pulse valid in the cycle after an accepted last beat
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= accept && last_i;
    end

    always_comb psum_valid_o = valid_q;

endmodule

// File: rtl/mac_pe_checker.sv
// Module: mac_pe_checker
// Temporal checks on the MAC element, attached to the top by bind.
module mac_pe_checker #(
    parameter int unsigned OPW   = 4,
    parameter int unsigned ACC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prec_i,
    input logic             in_valid_i,
    input logic             start_i,
    input logic             last_i,
    input logic [OPW-1:0]   wgt_i,
    input logic [ACC_W-1:0] psum_o,
    input logic             psum_valid_o,
    input logic             ovf_o,
    input logic             busy_q
);

    logic wgt_neg;
    always_comb wgt_neg = prec_i ? wgt_i[1] : wgt_i[OPW-1];

    // R7: valid follows only an accepted last beat
    assert_valid_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        psum_valid_o |-> $past(in_valid_i && last_i && (start_i || busy_q)));

    // R3: a non-negative product never lowers the running sum (no wrap)
    assert_no_wrap_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !start_i && busy_q && !wgt_neg)
        |=> $signed(psum_o) >= $signed($past(psum_o)));

    // R3: a negative product never raises the running sum (no wrap)
    assert_no_wrap_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !start_i && busy_q && wgt_neg)
        |=> $signed(psum_o) <= $signed($past(psum_o)));

    // R4: the flag rises only with a clamped value on the output
    assert_ovf_at_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> (psum_o == {1'b0, {(ACC_W-1){1'b1}}} ||
                          psum_o == {1'b1, {(ACC_W-1){1'b0}}}));

    // R4: the flag holds until a start beat
    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !(in_valid_i && start_i)) |=> ovf_o);

    // R2: a start beat clears the flag (bias plus one product cannot clamp)
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && start_i) |=> !ovf_o);

    // R9: an idle cycle leaves the sum unchanged
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> $stable(psum_o));

    // R8: beats outside an open output leave the sum unchanged
    assert_closed_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !start_i && !busy_q) |=> ($stable(psum_o) && !psum_valid_o));

endmodule

bind mixsign_mac_pe mac_pe_checker #(.OPW(OPW), .ACC_W(ACC_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .prec_i       (prec_i),
    .in_valid_i   (in_valid_i),
    .start_i      (start_i),
    .last_i       (last_i),
    .wgt_i        (wgt_i),
    .psum_o       (psum_o),
    .psum_valid_o (psum_valid_o),
    .ovf_o        (ovf_o),
    .busy_q       (busy_q)
);

// File: tb/mixsign_mac_pe_tb_top.sv
module mixsign_mac_pe_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prec_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic        start_i = 1'b0;
    logic        last_i = 1'b0;
    logic [7:0]  bias_i = '0;
    logic [3:0]  wgt_i = '0;
    logic [3:0]  act_i = '0;
    logic [15:0] psum_o;
    logic        psum_valid_o;
    logic        ovf_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mixsign_mac_pe dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .prec_i       (prec_i),
        .in_valid_i   (in_valid_i),
        .start_i      (start_i),
        .last_i       (last_i),
        .bias_i       (bias_i),
        .wgt_i        (wgt_i),
        .act_i        (act_i),
        .psum_o       (psum_o),
        .psum_valid_o (psum_valid_o),
        .ovf_o        (ovf_o)
    );

    typedef struct packed {
        logic              prec;
        logic              st;
        logic              lst;
        logic [7:0]        bias;
        logic [3:0]        w;
        logic [3:0]        a;
        logic signed [15:0] exp_sum;
        logic              exp_vld;
    } vec_t;

    // Beats with the expected sum and valid seen in the following cycle
    localparam vec_t VEC [10] = '{
        '{1'b0, 1'b1, 1'b0, 8'd10,  4'h3, 4'h5,  16'sd25,   1'b0},
        '{1'b0, 1'b0, 1'b0, 8'd0,   4'h8, 4'hF, -16'sd95,   1'b0},
        '{1'b0, 1'b0, 1'b1, 8'd0,   4'h7, 4'hF,  16'sd10,   1'b1},
        '{1'b0, 1'b1, 1'b1, 8'h80,  4'h8, 4'hF, -16'sd248,  1'b1},
        '{1'b1, 1'b1, 1'b0, 8'd0,   4'hE, 4'h7, -16'sd6,    1'b0},
        '{1'b1, 1'b0, 1'b0, 8'd0,   4'h5, 4'hE, -16'sd4,    1'b0},
        '{1'b1, 1'b0, 1'b1, 8'd0,   4'hB, 4'hF, -16'sd7,    1'b1},
        '{1'b0, 1'b1, 1'b0, 8'd127, 4'h0, 4'h0,  16'sd127,  1'b0},
        '{1'b0, 1'b0, 1'b1, 8'd0,   4'hF, 4'h1,  16'sd126,  1'b1},
        '{1'b0, 1'b1, 1'b1, 8'd0,   4'hE, 4'hE, -16'sd28,   1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one valid beat, let one edge pass, return at the next falling edge
    task automatic beat(input logic p, input logic s, input logic l,
                        input logic [7:0] b, input logic [3:0] w, input logic [3:0] a);
        prec_i = p; start_i = s; last_i = l; bias_i = b; wgt_i = w; act_i = a;
        in_valid_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid_i = 1'b0; start_i = 1'b0; last_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 psum", int'($signed(psum_o)), 0);
        chk("R1 valid", int'(psum_valid_o), 0);
        chk("R1 ovf", int'(ovf_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2, R5, R6, R7, R10
        for (int i = 0; i < 10; i++) begin
            string tg;
            tg = VEC[i].prec ? "R6 table sum" : "R5 table sum";
            beat(VEC[i].prec, VEC[i].st, VEC[i].lst, VEC[i].bias, VEC[i].w, VEC[i].a);
            chk(tg, int'($signed(psum_o)), int'(VEC[i].exp_sum));
            chk("R7 table valid", int'(psum_valid_o), int'(VEC[i].exp_vld));
            chk("R4 table ovf", int'(ovf_o), 0);
        end

        // R7: valid lasts exactly one cycle
        @(negedge clk);
        chk("R7 single pulse", int'(psum_valid_o), 0);

        // R8: beats after a last beat, without start, are ignored
        beat(1'b0, 1'b0, 1'b0, 8'd50, 4'h7, 4'hF);
        chk("R8 sum hold", int'($signed(psum_o)), -28);
        beat(1'b0, 1'b0, 1'b1, 8'd50, 4'h7, 4'hF);
        chk("R8 no valid", int'(psum_valid_o), 0);

        // R9: idle cycles with noisy controls change nothing
        beat(1'b0, 1'b1, 1'b0, 8'd20, 4'h2, 4'h3);           // 26
        prec_i = 1'b1; start_i = 1'b1; last_i = 1'b1; wgt_i = 4'h7; act_i = 4'hF; bias_i = 8'h80;
        repeat (3) @(negedge clk);
        start_i = 1'b0; last_i = 1'b0;
        chk("R9 idle hold", int'($signed(psum_o)), 26);
        chk("R9 idle no valid", int'(psum_valid_o), 0);
        beat(1'b0, 1'b0, 1'b1, 8'd0, 4'h1, 4'h4);            // 30, output still open
        chk("R9 open after idle", int'($signed(psum_o)), 30);
        chk("R7 valid after idle", int'(psum_valid_o), 1);

        // R3/R4: positive clamp, sticky flag, recovery
        beat(1'b0, 1'b1, 1'b0, 8'd127, 4'h7, 4'hF);          // 232
        chk("R4 ovf clear before clamp", int'(ovf_o), 0);
        for (int n = 0; n < 320; n++) beat(1'b0, 1'b0, 1'b0, 8'd0, 4'h7, 4'hF);
        chk("R3 clamp high", int'($signed(psum_o)), 32767);
        chk("R4 ovf set high", int'(ovf_o), 1);
        beat(1'b0, 1'b0, 1'b0, 8'd0, 4'hF, 4'h1);            // 32766
        chk("R3 live after clamp", int'($signed(psum_o)), 32766);
        chk("R4 ovf sticky", int'(ovf_o), 1);
        beat(1'b0, 1'b0, 1'b1, 8'd0, 4'h0, 4'h9);
        chk("R7 clamp output valid", int'(psum_valid_o), 1);
        chk("R4 ovf at output", int'(ovf_o), 1);
        beat(1'b0, 1'b1, 1'b0, 8'd0, 4'h1, 4'h1);
        chk("R4 ovf cleared by start", int'(ovf_o), 0);
        chk("R2 restart sum", int'($signed(psum_o)), 1);

        // R3/R4: negative clamp
        beat(1'b0, 1'b1, 1'b0, 8'h80, 4'h8, 4'hF);           // -248
        for (int n = 0; n < 280; n++) beat(1'b0, 1'b0, 1'b0, 8'd0, 4'h8, 4'hF);
        chk("R3 clamp low", int'($signed(psum_o)), -32768);
        chk("R4 ovf set low", int'(ovf_o), 1);
        beat(1'b0, 1'b0, 1'b1, 8'd0, 4'h1, 4'h3);            // -32765
        chk("R3 live after low clamp", int'($signed(psum_o)), -32765);
        chk("R7 low output valid", int'(psum_valid_o), 1);

        // R6: upper lane bits ignored in narrow setting
        beat(1'b1, 1'b1, 1'b1, 8'd0, 4'hD, 4'hD);            // 1 * 1
        chk("R6 upper bits ignored", int'($signed(psum_o)), 1);
        beat(1'b1, 1'b1, 1'b1, 8'hFF, 4'h6, 4'hB);           // -1 + (-2*3)
        chk("R6 narrow sign", int'($signed(psum_o)), -7);

        finish_run();
    end

endmodule